// File: doc/BRIEF.md
# Multi-mode GPIO pin controller

This block runs six general-purpose pins for a serial bridge device. Software sets it up through a byte-wide register bus. There are four configuration registers: a mode selector, a pin direction byte, an interrupt mask byte and an output data byte. There are also two read-only views: the sticky change status and the synchronised pin levels. Pins that the mode selector does not claim act as plain inputs or outputs, as the direction byte sets for each pin.

The mode selector can take pins away from software and hand them to hardware handshakes:

- Request-to-send / clear-to-send flow control uses pins 4 and 5.
- Data-terminal-ready / data-set-ready flow control uses pins 2 and 3.
- A half-duplex line-driver enable on pin 5 has selectable polarity. It follows either the transmit-active signal or the address-match signal.

Each handshake input that a claimed pin carries is handed to the flow-control logic outside this block. Each handshake output is driven from a port.

Pin inputs pass through a synchroniser. A change of level on a pin that is a software input and is unmasked sets a sticky per-pin status bit. The interrupt request is the OR of those bits. Reading the status byte clears it.

Top module: `gpio_pinmux_ctrl`

## Requirements
- R1: After reset all pins are undriven (`pin_oe` = 0, `pin_o` = 0), `irq` is low, and addresses 0 to 4 read 0.
- R2: Address 0 holds the mode. Bits [2:0] select the mode and bit 3 sets the line-driver polarity. Bits [7:4] are dropped on write and read as 0.
- R3: Address 1 (direction), address 2 (interrupt mask) and address 3 (output data) each store bits [5:0]. Bits [7:6] read as 0. Addresses 6 and 7 read 0.
- R4: A pin that the mode does not claim is an output when its direction bit is 1. It then drives its output data bit with `pin_oe` = 1. When its direction bit is 0 it is an input: `pin_oe` = 0 and `pin_o` = 0.
- R5: Mode 001 claims pin 4 as an input whatever its direction bit. `cts_n_o` follows the synchronised level of pin 4. Pin 5 is driven from `rts_n_i`. In every other mode `cts_n_o` is 1.
- R6: Mode 010 claims pin 2 as an input, and `dsr_n_o` follows its synchronised level. Pin 3 is driven from `dtr_n_i`. In every other mode `dsr_n_o` is 1.
- R7: Mode 011 drives pin 5 as the line-driver enable from `xcvr_tx_i`. With mode bit 3 = 1 the pin equals `xcvr_tx_i`. With mode bit 3 = 0 it is the inverse.
- R8: Mode 100 drives pin 5 the same way as R7, but from `xcvr_addr_i`. `xcvr_tx_i` has no effect on the pin in this mode.
- R9: Mode codes 101, 110 and 111 behave as 000: no pin is claimed.
- R10: A level change on an unclaimed input pin whose mask bit is 0 sets that pin's status bit on the third rising clock edge after the change. `irq` is high while any status bit is set.
- R11: Level changes on masked pins, on output pins and on claimed pins set no status bit.
- R12: Address 4 returns the status in bits [5:0]. A read strobe there clears the status. A change detected on the same edge as the clear stays set.
- R13: Address 5 returns the synchronised pin levels in bits [5:0]. These lag `pin_i` by two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status at address 4) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pin_i | input | 6 | Pad input levels |
| pin_o | output | 6 | Pad output values |
| pin_oe | output | 6 | Pad output enables |
| rts_n_i | input | 1 | Request-to-send level for pin 5 in mode 001 |
| dtr_n_i | input | 1 | Terminal-ready level for pin 3 in mode 010 |
| xcvr_tx_i | input | 1 | Transmit-active indication for mode 011 |
| xcvr_addr_i | input | 1 | Address-match indication for mode 100 |
| cts_n_o | output | 1 | Clear-to-send level taken from pin 4 |
| dsr_n_o | output | 1 | Set-ready level taken from pin 2 |
| irq | output | 1 | Interrupt request, OR of the status bits |

## Verification
The bench builds the block with its default parameters: six pins and a two-stage synchroniser. At those values every pin index used by the mode table exists, so each claimed-pin mapping and each reserved-bit boundary in the registers can be reached. The two-stage depth fixes the detection latency at three edges. The bench measures that latency exactly, and it also aligns a status read with a detection edge to exercise the set-over-clear race.

// File: rtl/gpio_pinmux_pkg.sv
package gpio_pinmux_pkg;
  localparam logic [2:0] MODE_GPIO     = 3'd0;
  localparam logic [2:0] MODE_RTSCTS   = 3'd1;
  localparam logic [2:0] MODE_DTRDSR   = 3'd2;
  localparam logic [2:0] MODE_XEN_TX   = 3'd3;
  localparam logic [2:0] MODE_XEN_ADDR = 3'd4;

  localparam logic [2:0] ADDR_MODE = 3'd0;
  localparam logic [2:0] ADDR_DIR  = 3'd1;
  localparam logic [2:0] ADDR_MASK = 3'd2;
  localparam logic [2:0] ADDR_DOUT = 3'd3;
  localparam logic [2:0] ADDR_STAT = 3'd4;
  localparam logic [2:0] ADDR_LVL  = 3'd5;

  // Fixed pin assignments of the hardware functions
  localparam int CTS_PIN = 4;
  localparam int RTS_PIN = 5;
  localparam int DSR_PIN = 2;
  localparam int DTR_PIN = 3;
  localparam int XEN_PIN = 5;

  typedef struct packed {
    logic       pol;  // line-driver enable polarity
    logic [2:0] sel;  // mode select
  } mode_cfg_t;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pinmux_pkg::*;
#(
  parameter int NPINS = 6,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       wdata,
  input  logic [NPINS-1:0] status,
  input  logic [NPINS-1:0] level,
  output logic [7:0]       rdata,
  output mode_cfg_t        mode,
  output logic [NPINS-1:0] dir,
  output logic [NPINS-1:0] mask,
  output logic [NPINS-1:0] dout,
  output logic             stat_clr
);
  mode_cfg_t        mode_q, mode_d;
  logic [NPINS-1:0] dir_q, dir_d, mask_q, mask_d, dout_q, dout_d;
  logic             unused_wbits;

  assign unused_wbits = ^wdata[7:NPINS];

  always_comb begin
    mode_d = mode_q;
    dir_d  = dir_q;
    mask_d = mask_q;
    dout_d = dout_q;
    if (wr) begin
      case (addr)
        ADDR_MODE: mode_d = wdata[3:0];
        ADDR_DIR:  dir_d  = wdata[NPINS-1:0];
        ADDR_MASK: mask_d = wdata[NPINS-1:0];
        ADDR_DOUT: dout_d = wdata[NPINS-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      mask_q <= '0;
      dout_q <= '0;
    end else if (wr) begin
      mode_q <= mode_d;
      dir_q  <= dir_d;
      mask_q <= mask_d;
      dout_q <= dout_d;
    end
  end

  always_comb begin
    case (addr)
      ADDR_MODE: rdata = {4'h0, mode_q};
      ADDR_DIR:  rdata = 8'(dir_q);
      ADDR_MASK: rdata = 8'(mask_q);
      ADDR_DOUT: rdata = 8'(dout_q);
      ADDR_STAT: rdata = 8'(status);
      ADDR_LVL:  rdata = 8'(level);
      default:   rdata = 8'h00;
    endcase
  end

  assign stat_clr = rd && (addr == ADDR_STAT);
  assign mode     = mode_q;
  assign dir      = dir_q;
  assign mask     = mask_q;
  assign dout     = dout_q;

  // R2: a mode write keeps only the low nibble
  assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_MODE) |=> (rdata[7:4] == 4'h0 || addr != ADDR_MODE) && (mode_q == $past(wdata[3:0])));
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_pinmux_pkg::*;
#(
  parameter int NPINS = 6
) (
  input  mode_cfg_t        mode,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] dout,
  input  logic             rts_n,
  input  logic             dtr_n,
  input  logic             xen_tx,
  input  logic             xen_addr,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] claimed
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic own_in, own_out, hw_val;

    always_comb begin
      own_in  = 1'b0;
      own_out = 1'b0;
      hw_val  = 1'b0;
      case (mode.sel)
        MODE_RTSCTS: begin
          if (i == CTS_PIN) own_in = 1'b1;
          if (i == RTS_PIN) begin own_out = 1'b1; hw_val = rts_n; end
        end
        MODE_DTRDSR: begin
          if (i == DSR_PIN) own_in = 1'b1;
          if (i == DTR_PIN) begin own_out = 1'b1; hw_val = dtr_n; end
        end
        MODE_XEN_TX: begin
          if (i == XEN_PIN) begin own_out = 1'b1; hw_val = mode.pol ? xen_tx : ~xen_tx; end
        end
        MODE_XEN_ADDR: begin
          if (i == XEN_PIN) begin own_out = 1'b1; hw_val = mode.pol ? xen_addr : ~xen_addr; end
        end
        default: ;
      endcase
    end

    assign claimed[i] = own_in | own_out;
    assign pin_oe[i]  = own_out | (~(own_in | own_out) & dir[i]);
    assign pin_o[i]   = own_out ? hw_val : (dir[i] & ~own_in & dout[i]);
  end
endmodule

// File: rtl/gpio_change_det.sv
module gpio_change_det #(
  parameter int NPINS       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] elig,
  input  logic             clr,
  output logic [NPINS-1:0] level,
  output logic [NPINS-1:0] status
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NPINS-1:0] sync_q [SYNC_STAGES];
  logic [NPINS-1:0] prev_q, status_q, status_d, set_v;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[s] <= '0;
        else        sync_q[s] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[s] <= '0;
        else        sync_q[s] <= sync_q[s-1];
    end
  end

  assign level = sync_q[LAST];

  always_comb begin
    set_v    = (level ^ prev_q) & elig;
    status_d = set_v | (status_q & ~{NPINS{clr}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= level;
      status_q <= status_d;
    end
  end

  assign status = status_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    // R11: a status bit only rises for a pin that was eligible
    assert_no_ineligible_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q[i]) |-> $past(elig[i]));
    // R12: status stays set until a clear strobe
    assert_status_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[i] && !clr) |=> status_q[i]);
  end
endmodule

// File: rtl/gpio_pinmux_ctrl.sv
module gpio_pinmux_ctrl
  import gpio_pinmux_pkg::*;
#(
  parameter int NPINS       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe,
  input  logic             rts_n_i,
  input  logic             dtr_n_i,
  input  logic             xcvr_tx_i,
  input  logic             xcvr_addr_i,
  output logic             cts_n_o,
  output logic             dsr_n_o,
  output logic             irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  mode_cfg_t        mode;
  logic [NPINS-1:0] dir, mask, dout, claimed, elig, level, status;
  logic             stat_clr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};

  assign rst_n_int = rst_sync_q[1];

  gpio_regs #(.NPINS(NPINS), .AW(AW)) i_regs (
    .clk(clk), .rst_n(rst_n_int), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .status(status), .level(level), .rdata(reg_rdata),
    .mode(mode), .dir(dir), .mask(mask), .dout(dout), .stat_clr(stat_clr)
  );

  gpio_pinmux #(.NPINS(NPINS)) i_mux (
    .mode(mode), .dir(dir), .dout(dout), .rts_n(rts_n_i), .dtr_n(dtr_n_i),
    .xen_tx(xcvr_tx_i), .xen_addr(xcvr_addr_i),
    .pin_o(pin_o), .pin_oe(pin_oe), .claimed(claimed)
  );

  assign elig = ~claimed & ~dir & ~mask;

  gpio_change_det #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) i_det (
    .clk(clk), .rst_n(rst_n_int), .pin_i(pin_i), .elig(elig), .clr(stat_clr),
    .level(level), .status(status)
  );

  assign cts_n_o = (mode.sel == MODE_RTSCTS) ? level[CTS_PIN] : 1'b1;
  assign dsr_n_o = (mode.sel == MODE_DTRDSR) ? level[DSR_PIN] : 1'b1;
  assign irq     = |status;

  // R5: in handshake mode the clear-to-send pin never drives, request-to-send always does
  assert_rtscts_pins_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mode.sel == MODE_RTSCTS) |-> (!pin_oe[CTS_PIN] && pin_oe[RTS_PIN]));
  // R10: irq drops the cycle after a clear when nothing new arrives
  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (stat_clr && elig == '0) |=> !irq);
endmodule

// File: tb/test_gpio_pinmux_ctrl.sv
module test_gpio_pinmux_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr, reg_rd;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [5:0] pin_i, pin_o, pin_oe;
  logic       rts_n_i, dtr_n_i, xcvr_tx_i, xcvr_addr_i;
  logic       cts_n_o, dsr_n_o, irq;
  int         total = 0;
  int         bad = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  gpio_pinmux_ctrl i_gpio_pinmux_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
    .rts_n_i(rts_n_i), .dtr_n_i(dtr_n_i), .xcvr_tx_i(xcvr_tx_i),
    .xcvr_addr_i(xcvr_addr_i), .cts_n_o(cts_n_o), .dsr_n_o(dsr_n_o), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic settle_and_clear();
    logic [7:0] tmp;
    repeat (4) @(negedge clk);
    rd(3'd4, tmp);
  endtask

  task automatic t_reset();
    check("R1 oe", {2'b0, pin_oe}, 8'h00);
    check("R1 out", {2'b0, pin_o}, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), rv);
      check("R1 reg", rv, 8'h00);
    end
  endtask

  task automatic t_regs();
    wr(3'd0, 8'hFB); rd(3'd0, rv); check("R2 mode", rv, 8'h0B);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'hFF); rd(3'd1, rv); check("R3 dir", rv, 8'h3F);
    wr(3'd2, 8'hC5); rd(3'd2, rv); check("R3 mask", rv, 8'h05);
    wr(3'd3, 8'hAA); rd(3'd3, rv); check("R3 dout", rv, 8'h2A);
    rd(3'd6, rv); check("R3 addr6", rv, 8'h00);
    rd(3'd7, rv); check("R3 addr7", rv, 8'h00);
    wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
  endtask

  task automatic t_gpio_out();
    wr(3'd1, 8'h15); wr(3'd3, 8'h3F);
    check("R4 oe", {2'b0, pin_oe}, 8'h15);
    check("R4 out", {2'b0, pin_o}, 8'h15);
    wr(3'd3, 8'h00);
    check("R4 out low", {2'b0, pin_o}, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_rtscts();
    wr(3'd0, 8'h01); wr(3'd1, 8'h3F); wr(3'd3, 8'h3F);
    rts_n_i = 1'b0; #1;
    check("R5 oe", {2'b0, pin_oe}, 8'h2F);
    check("R5 rts low", {2'b0, pin_o}, 8'h0F);
    rts_n_i = 1'b1; #1;
    check("R5 rts high", {2'b0, pin_o}, 8'h2F);
    pin_i[4] = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 cts low", {7'b0, cts_n_o}, 8'h00);
    pin_i[4] = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 cts high", {7'b0, cts_n_o}, 8'h01);
    pin_i[4] = 1'b0;
    wr(3'd0, 8'h00);
    repeat (3) @(negedge clk);
    check("R5 cts idle", {7'b0, cts_n_o}, 8'h01);
    wr(3'd1, 8'h00); wr(3'd3, 8'h00);
  endtask

  task automatic t_dtrdsr();
    wr(3'd0, 8'h02); wr(3'd1, 8'h3F);
    dtr_n_i = 1'b1; #1;
    check("R6 oe", {2'b0, pin_oe}, 8'h3B);
    check("R6 dtr", {2'b0, pin_o}, 8'h08);
    pin_i[2] = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 dsr low", {7'b0, dsr_n_o}, 8'h00);
    pin_i[2] = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 dsr high", {7'b0, dsr_n_o}, 8'h01);
    wr(3'd0, 8'h00);
    check("R6 dsr idle", {7'b0, dsr_n_o}, 8'h01);
    pin_i[2] = 1'b0;
    wr(3'd1, 8'h00);
  endtask

  task automatic t_xen();
    wr(3'd0, 8'h03);
    xcvr_tx_i = 1'b1; #1;
    check("R7 oe", {2'b0, pin_oe}, 8'h20);
    check("R7 pol0 tx", {2'b0, pin_o}, 8'h00);
    xcvr_tx_i = 1'b0; #1;
    check("R7 pol0 idle", {2'b0, pin_o}, 8'h20);
    wr(3'd0, 8'h0B);
    xcvr_tx_i = 1'b1; #1;
    check("R7 pol1 tx", {2'b0, pin_o}, 8'h20);
    wr(3'd0, 8'h0C);
    xcvr_addr_i = 1'b1; xcvr_tx_i = 1'b0; #1;
    check("R8 addr hit", {2'b0, pin_o}, 8'h20);
    xcvr_addr_i = 1'b0; xcvr_tx_i = 1'b1; #1;
    check("R8 tx ignored", {2'b0, pin_o}, 8'h00);
    xcvr_tx_i = 1'b0;
    wr(3'd0, 8'h00);
  endtask

  task automatic t_alias();
    wr(3'd1, 8'h3F); wr(3'd3, 8'h3F);
    for (int m = 5; m < 8; m++) begin
      wr(3'd0, 8'(m));
      check("R9 oe", {2'b0, pin_oe}, 8'h3F);
      check("R9 out", {2'b0, pin_o}, 8'h3F);
    end
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd3, 8'h00);
  endtask

  task automatic t_irq();
    settle_and_clear();
    check("R10 idle", {7'b0, irq}, 8'h00);
    pin_i[1] = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 not yet", {7'b0, irq}, 8'h00);
    @(negedge clk);
    check("R10 raised", {7'b0, irq}, 8'h01);
    rd(3'd5, rv); check("R13 level", rv, 8'h02);
    rd(3'd4, rv); check("R12 status", rv, 8'h02);
    rd(3'd4, rv); check("R12 cleared", rv, 8'h00);
    check("R12 irq low", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_irq_blocked();
    settle_and_clear();
    wr(3'd2, 8'h01);
    pin_i[0] = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd4, rv); check("R11 masked", rv, 8'h00);
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h08);
    pin_i[3] = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd4, rv); check("R11 output", rv, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h01);
    pin_i[4] = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd4, rv); check("R11 claimed", rv, 8'h00);
    check("R11 irq", {7'b0, irq}, 8'h00);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_clear_race();
    settle_and_clear();
    pin_i[5] = 1'b1;
    repeat (2) @(negedge clk);
    rd(3'd4, rv); check("R12 race old", rv, 8'h00);
    check("R12 race irq", {7'b0, irq}, 8'h01);
    rd(3'd4, rv); check("R12 race kept", rv, 8'h20);
    check("R12 race clr", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    pin_i = '0; rts_n_i = 1'b1; dtr_n_i = 1'b1; xcvr_tx_i = 1'b0; xcvr_addr_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_gpio_out();
    t_rtscts();
    t_dtrdsr();
    t_xen();
    t_alias();
    t_irq();
    t_irq_blocked();
    t_clear_race();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule